// File: doc/BRIEF.md
# Bus Hold Handshake Controller with Posted-Write Drain

This block settles who owns the PCI bus when a legacy I/O bridge asks for it. The bridge signals its wish on an active-low hold request. The controller does not grant at once. It first asks the host bridge's outbound posted-write buffer to drain and waits for that buffer to report empty. It then blocks further posting and only then drives its active-low hold acknowledge. This ordering prevents a deadlock between outbound CPU writes and traffic coming up from the ISA side. While the buffer is draining, granted or being released, new CPU-to-PCI writes are answered with a retry.

A second function keeps interrupt messages in order behind inbound memory writes. Each inbound write accepted from the I/O bridge arrives with the number of host-bus snoops it has caused. The block counts those snoops down as they finish. It drives an active-low write-snoop-complete signal only when none are outstanding. A configuration bit turns the mechanism off and forces the signal high, for systems that have no I/O interrupt controller.

Top module: `hold_flush_ctl`

## Requirements
- R1: A synchronous active-high reset puts the block in idle with hold_ack_n high, pwb_flush low, pwb_disable low and cpu_wr_retry low. The snoop counter is cleared, and wsc_n equals wsc_off while reset is held.
- R2: A low hold_req_n seen in idle raises pwb_flush from the next clock. pwb_flush stays high, and hold_ack_n stays high, for as long as pwb_empty is low and the request is held.
- R3: hold_ack_n goes low only on the clock after a cycle in which pwb_flush was high, pwb_empty was high and hold_req_n was low. At least one flush cycle always comes first, even when the buffer is already empty. pwb_disable rises on that same clock and stays high while hold_ack_n is low, whatever pwb_empty does.
- R4: cpu_wr_retry equals cpu_wr_valid in the flush, granted and release phases, and is low in idle.
- R5: When hold_req_n goes high while granted, hold_ack_n goes high on the next clock and pwb_disable falls one clock after that.
- R6: If hold_req_n goes high during the flush phase, the block returns to idle on the next clock. It never drives hold_ack_n low and never raises pwb_disable. A withdrawal outranks pwb_empty seen in the same cycle.
- R7: A request that is held or reasserted during the release clock is served only after a return to idle. The sequence is release, idle, flush, then grant.
- R8: With wsc_off low, an ib_wr_accept carrying ib_snoop_cnt = N > 0 drives wsc_n high from the next clock. Each snoop_done lowers the count by one, and wsc_n goes low on the clock after the count reaches zero. An accept and a done in the same cycle net to count + N - 1. A snoop_done while the count is zero is ignored.
- R9: An ib_wr_accept with ib_snoop_cnt = 0 leaves the count unchanged, so with nothing outstanding wsc_n stays low.
- R10: While wsc_off is high, wsc_n is high from the next clock whatever the count. The count keeps being tracked, so after clearing wsc_off, wsc_n stays high until the snoops still outstanding have finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hold_req_n | input | 1 | Bus hold request from the I/O bridge, active low |
| hold_ack_n | output | 1 | Bus hold acknowledge, active low |
| pwb_flush | output | 1 | Request to drain the outbound posted-write buffer |
| pwb_empty | input | 1 | Posted-write buffer holds no writes |
| pwb_disable | output | 1 | Block new posting into the buffer |
| cpu_wr_valid | input | 1 | CPU presents a CPU-to-PCI write |
| cpu_wr_retry | output | 1 | That write must be retried |
| ib_wr_accept | input | 1 | An inbound PCI-to-DRAM write was accepted |
| ib_snoop_cnt | input | CNT_W | Number of host snoops that write caused |
| snoop_done | input | 1 | One outstanding snoop finished |
| wsc_off | input | 1 | Configuration bit: write-snoop-complete disabled |
| wsc_n | output | 1 | Write snoop complete, active low |

## Verification
The hold handshake is driven by one table of input patterns. The patterns separate an empty buffer that arrives late from one that is already empty when the request comes, and a grant that ignores a buffer later reporting non-empty. They also separate a request withdrawn while flushing from one withdrawn together with the empty report, and a request reasserted during release. Each step compares acknowledge, flush, disable and retry, so a state that decodes its outputs wrongly stands out from a wrong transition. The snoop-complete tests contrast a multi-snoop write, an accept and done in the same cycle, a zero-snoop write, a stray done at zero, and toggling the disable bit while snoops are outstanding. A reset applied while granted is also tried.

// File: rtl/hold_flush_ctl.sv
module hold_flush_ctl #(
  parameter int CNT_W = 4,
  parameter int ACC_W = CNT_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold_req_n,
  output logic             hold_ack_n,
  output logic             pwb_flush,
  input  logic             pwb_empty,
  output logic             pwb_disable,
  input  logic             cpu_wr_valid,
  output logic             cpu_wr_retry,
  input  logic             ib_wr_accept,
  input  logic [CNT_W-1:0] ib_snoop_cnt,
  input  logic             snoop_done,
  input  logic             wsc_off,
  output logic             wsc_n
);

  typedef enum logic [1:0] {S_IDLE, S_FLUSH, S_GRANT, S_REL} st_t;

  st_t st, st_nx;
  logic [ACC_W-1:0] cnt, cnt_nx, add;
  logic [ACC_W:0]   sum_w;
  logic             dec, wsc_q;

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE:  if (!hold_req_n) st_nx = S_FLUSH;
      S_FLUSH: if (hold_req_n) st_nx = S_IDLE;
               else if (pwb_empty) st_nx = S_GRANT;
      S_GRANT: if (hold_req_n) st_nx = S_REL;
      S_REL:   st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= S_IDLE;
    else     st <= st_nx;
  end

  assign hold_ack_n   = (st != S_GRANT);
  assign pwb_flush    = (st == S_FLUSH);
  assign pwb_disable  = (st == S_GRANT) || (st == S_REL);
  assign cpu_wr_retry = cpu_wr_valid && (st != S_IDLE);

  assign add    = ib_wr_accept ? {{(ACC_W-CNT_W){1'b0}}, ib_snoop_cnt} : '0;
  assign dec    = snoop_done && (cnt != '0);
  assign sum_w  = {1'b0, cnt} + {1'b0, add};
  assign cnt_nx = sum_w[ACC_W-1:0] - {{(ACC_W-1){1'b0}}, dec};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      wsc_q <= wsc_off;
    end else begin
      cnt   <= cnt_nx;
      wsc_q <= wsc_off || (cnt_nx != '0);
    end
  end

  assign wsc_n = wsc_q;

  // R3
  ack_after_flush_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(hold_ack_n) |-> ($past(pwb_flush) && $past(pwb_empty) && !$past(hold_req_n)));

  // R3
  ack_blocks_buf_chk: assert property (@(posedge clk) disable iff (rst)
    !hold_ack_n |-> pwb_disable);

  // R4
  retry_chk: assert property (@(posedge clk) disable iff (rst)
    (pwb_disable && cpu_wr_valid) |-> cpu_wr_retry);

  // R5
  ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold_ack_n && hold_req_n) |=> hold_ack_n);

  // R5
  reenable_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_ack_n) |=> !pwb_disable);

  // R6
  withdraw_chk: assert property (@(posedge clk) disable iff (rst)
    (pwb_flush && hold_req_n) |=> (hold_ack_n && !pwb_disable && !pwb_flush));

  // R8
  wsc_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (ib_wr_accept && ib_snoop_cnt != '0) |=> wsc_n);

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    ib_wr_accept |-> !sum_w[ACC_W]);

  // R10
  wsc_off_chk: assert property (@(posedge clk) disable iff (rst)
    wsc_off |=> wsc_n);

endmodule

// File: tb/hold_flush_ctl_tb.sv
module hold_flush_ctl_tb;
  localparam int CNT_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hold_req_n = 1'b1, pwb_empty = 1'b0, cpu_wr_valid = 1'b0;
  logic ib_wr_accept = 1'b0, snoop_done = 1'b0, wsc_off = 1'b0;
  logic [CNT_W-1:0] ib_snoop_cnt = '0;
  logic hold_ack_n, pwb_flush, pwb_disable, cpu_wr_retry, wsc_n;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2 clk = ~clk;

  hold_flush_ctl #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .hold_req_n(hold_req_n), .hold_ack_n(hold_ack_n),
    .pwb_flush(pwb_flush), .pwb_empty(pwb_empty), .pwb_disable(pwb_disable),
    .cpu_wr_valid(cpu_wr_valid), .cpu_wr_retry(cpu_wr_retry),
    .ib_wr_accept(ib_wr_accept), .ib_snoop_cnt(ib_snoop_cnt),
    .snoop_done(snoop_done), .wsc_off(wsc_off), .wsc_n(wsc_n)
  );

  // {req_n, empty, wr_valid, exp ack_n, exp flush, exp disable, exp retry}
  localparam logic [6:0] VEC [16] = '{
    7'b100_1000, 7'b101_1000, 7'b000_1100, 7'b001_1101,
    7'b010_0010, 7'b011_0011, 7'b110_1010, 7'b111_1000,
    7'b010_1100, 7'b010_0010, 7'b000_0010, 7'b100_1010,
    7'b000_1000, 7'b000_1100, 7'b110_1000, 7'b100_1000
  };

  task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #1;
    step(); step();
    // R1 reset state
    chk({hold_ack_n, pwb_flush, pwb_disable, wsc_n}, 4'b1000, "R1 reset outputs");
    rst = 1'b0;
    step();
    chk({hold_ack_n, pwb_flush, pwb_disable, cpu_wr_retry}, 4'b1000, "R1 idle after reset");

    // R2 R3 R4 R5 R6 R7 table walk
    foreach (VEC[i]) begin
      hold_req_n   = VEC[i][6];
      pwb_empty    = VEC[i][5];
      cpu_wr_valid = VEC[i][4];
      step();
      chk({hold_ack_n, pwb_flush, pwb_disable, cpu_wr_retry}, VEC[i][3:0],
          $sformatf("R2/R3/R4/R5/R6/R7 vector %0d", i));
    end

    // R6 withdraw with buffer never empty: ack never seen
    hold_req_n = 1'b0; pwb_empty = 1'b0; step();
    repeat (3) step();
    chk({hold_ack_n, pwb_flush, pwb_disable, 1'b0}, 4'b1100, "R2 flush held while not empty");
    hold_req_n = 1'b1; step();
    chk({hold_ack_n, pwb_flush, pwb_disable, 1'b0}, 4'b1000, "R6 withdraw to idle");

    // R1 reset while granted
    hold_req_n = 1'b0; pwb_empty = 1'b1; step(); step();
    chk({hold_ack_n, pwb_flush, pwb_disable, 1'b0}, 4'b0010, "R3 granted before reset");
    rst = 1'b1; step();
    chk({hold_ack_n, pwb_flush, pwb_disable, 1'b0}, 4'b1000, "R1 reset from granted");
    hold_req_n = 1'b1; rst = 1'b0; step();

    // R8 multi-snoop write
    chk({3'b0, wsc_n}, 4'b0000, "R8 idle wsc asserted");
    ib_wr_accept = 1'b1; ib_snoop_cnt = 4'd2; step();
    ib_wr_accept = 1'b0;
    chk({3'b0, wsc_n}, 4'b0001, "R8 wsc deasserts on accept");
    snoop_done = 1'b1; step();
    chk({3'b0, wsc_n}, 4'b0001, "R8 one snoop left");
    step();
    chk({3'b0, wsc_n}, 4'b0000, "R8 wsc after last done");
    step();
    chk({3'b0, wsc_n}, 4'b0000, "R8 done at zero ignored");
    // R8 accept plus done same cycle
    ib_wr_accept = 1'b1; ib_snoop_cnt = 4'd1; snoop_done = 1'b1; step();
    ib_wr_accept = 1'b0; snoop_done = 1'b0;
    chk({3'b0, wsc_n}, 4'b0001, "R8 accept with done at zero");
    ib_wr_accept = 1'b1; ib_snoop_cnt = 4'd1; snoop_done = 1'b1; step();
    ib_wr_accept = 1'b0; snoop_done = 1'b0;
    chk({3'b0, wsc_n}, 4'b0001, "R8 accept and done net");
    snoop_done = 1'b1; step(); snoop_done = 1'b0;
    chk({3'b0, wsc_n}, 4'b0000, "R8 drained");

    // R9 zero-snoop write
    ib_wr_accept = 1'b1; ib_snoop_cnt = 4'd0; step();
    ib_wr_accept = 1'b0;
    chk({3'b0, wsc_n}, 4'b0000, "R9 zero snoop write");

    // R10 disable bit
    wsc_off = 1'b1; step();
    chk({3'b0, wsc_n}, 4'b0001, "R10 off forces high");
    ib_wr_accept = 1'b1; ib_snoop_cnt = 4'd2; step();
    ib_wr_accept = 1'b0;
    wsc_off = 1'b0; step();
    chk({3'b0, wsc_n}, 4'b0001, "R10 outstanding after enable");
    snoop_done = 1'b1; step();
    chk({3'b0, wsc_n}, 4'b0001, "R10 one left");
    step(); snoop_done = 1'b0;
    chk({3'b0, wsc_n}, 4'b0000, "R10 drained after enable");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule